// File: doc/BRIEF.md
# AC-link Output Frame Serializer

This block produces the controller-to-codec direction of an AC-link: a continuous stream of 256-bit time-division frames on one serial data line, plus the frame sync, all timed by the bit clock that the codec supplies. Each frame opens with a 16-bit tag slot. The tag carries a frame-valid flag, one valid flag for each data slot, and a two-bit codec ID. Twelve 20-bit data slots follow the tag: a command address, command write data, left and right PCM playback, a modem sample, six reserved slots, and an I/O control word.

The slot contents come from plain holding inputs: a valid flag for each slot and one value for each kind of slot. The block samples them exactly once per frame, on the bit-clock edge just before the first tag bit. It raises a one-cycle frame-start strobe while that first bit is on the line, which tells the upstream logic that it may now load the next frame's contents. A shut-off input silences the link and, when released, restarts it cleanly at a frame boundary.

Top module: `aclink_frame_tx`

## Requirements
- R1: While running, a frame lasts exactly 256 bit-clock cycles. `frame_start_o` is high for exactly one cycle per frame, the cycle in which the first tag bit is on the line.
- R2: `sync_o` rises together with the first tag bit and stays high for exactly the 16 tag-bit cycles of each frame.
- R3: Every slot is sent most significant bit first, and outputs change only on the rising edge of `bclk`. Tag bit 15 goes first, then bits 19 down to 0 of slot 1 through slot 12 in turn.
- R4: Tag bit 15 is 1 when any slot is valid. Tag bits 14 down to 3 carry the valid flags of slots 1 to 12, in that order. Tag bit 2 is 0. Tag bits 1:0 carry `codec_id_i`, where 00 selects the primary codec and any other value a secondary one.
- R5: Slot 1 carries the read flag in bit 19 (1 = read) and the 7-bit register index in bits 18:12, with bits 11:0 zero. Slot 2 carries the 16-bit write data in bits 19:4, with bits 3:0 zero.
- R6: Slots 3, 4, 5 and 12 carry `pcm_left_i`, `pcm_right_i`, `modem_i` and `io_word_i` in bits 19:4, with bits 3:0 zero. Slots 6 to 11 always carry zeros.
- R7: A slot whose valid flag is 0 carries all zeros. When no slot is valid, the whole frame is zero, including the codec ID.
- R8: Slot inputs are sampled only on the edge that starts a frame. Changing them during a frame does not alter the frame in progress.
- R9: From the first rising edge at which `shutoff_i` is sampled high, `sdata_o`, `sync_o` and `frame_start_o` are low. On the first edge after release, a new frame begins with freshly sampled inputs.
- R10: During reset all outputs are low. The first frame begins on the first rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the codec (12.288 MHz) |
| rst_n | input | 1 | Active-low reset, synchronous to `bclk` |
| shutoff_i | input | 1 | Forces data and sync low while high |
| slot_vld_i | input | 12 | Valid flag for each slot; bit n belongs to slot n |
| codec_id_i | input | 2 | Codec ID placed in tag bits 1:0 |
| cmd_read_i | input | 1 | Command direction, 1 = read |
| cmd_index_i | input | 7 | Codec register index |
| cmd_wdata_i | input | 16 | Command write data |
| pcm_left_i | input | 16 | Left playback sample |
| pcm_right_i | input | 16 | Right playback sample |
| modem_i | input | 16 | Modem sample |
| io_word_i | input | 16 | I/O control word |
| sdata_o | output | 1 | Serial data line |
| sync_o | output | 1 | Frame sync |
| frame_start_o | output | 1 | One-cycle strobe at the first bit of each frame |

## Verification
The bench builds the block with its default geometry: a 16-bit tag, twelve 20-bit slots and 16-bit samples. That is the only configuration in which the 256-bit frame and the fixed slot map can be checked bit for bit against a model written independently of the RTL. At these values the bench reaches the all-zero frame, partial valid masks, a non-zero codec ID, the reserved slots, corruption of inputs in mid-frame, and the restart after shut-off.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;

  typedef enum logic [1:0] {
    SLOT_CMD_ADDR,
    SLOT_CMD_DATA,
    SLOT_SAMPLE,
    SLOT_RESERVED
  } slot_kind_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_LEFT,
    SRC_RIGHT,
    SRC_MODEM,
    SRC_IO
  } sample_src_e;

  // What a data slot carries; slot numbers count from 1.
  function automatic slot_kind_e kind_of_slot(input int s, input int last);
    if (s == 1) return SLOT_CMD_ADDR;
    if (s == 2) return SLOT_CMD_DATA;
    if ((s >= 3 && s <= 5) || s == last) return SLOT_SAMPLE;
    return SLOT_RESERVED;
  endfunction

  // Which sample input feeds a sample slot.
  function automatic sample_src_e src_of_slot(input int s, input int last);
    if (s == 3) return SRC_LEFT;
    if (s == 4) return SRC_RIGHT;
    if (s == 5) return SRC_MODEM;
    if (s == last) return SRC_IO;
    return SRC_NONE;
  endfunction

  // Frame bit index of the MSB of data slot s.
  function automatic int slot_top(input int s, input int frame_w, input int tag_w,
                                  input int slot_w);
    return frame_w - 1 - tag_w - (s - 1) * slot_w;
  endfunction

endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
  parameter int FRAME_W = 256,
  parameter int TAG_W   = 16,
  parameter int POS_W   = 8
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             shutoff_i,
  output logic             load_o,
  output logic             sync_o,
  output logic             frame_start_o,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_W - 1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nxt;

  assign pos_nxt = (pos_q == LAST) ? '0 : pos_q + 1'b1;
  assign load_o  = (pos_q == LAST) && !shutoff_i;
  assign pos_o   = pos_q;

  always_ff @(posedge bclk) begin
    if (!rst_n || shutoff_i) begin
      pos_q         <= LAST;
      sync_o        <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      pos_q         <= pos_nxt;
      sync_o        <= (int'(pos_nxt) < TAG_W);
      frame_start_o <= (pos_nxt == '0);
    end
  end
endmodule

// File: rtl/aclink_frame_builder.sv
module aclink_frame_builder import aclink_tx_pkg::*; #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int SAMPLE_W  = 16,
  parameter int IDX_W     = 7,
  parameter int CID_W     = 2,
  parameter int FRAME_W   = 256
) (
  input  logic [NUM_SLOTS:1]  slot_vld_i,
  input  logic [CID_W-1:0]    codec_id_i,
  input  logic                cmd_read_i,
  input  logic [IDX_W-1:0]    cmd_index_i,
  input  logic [SAMPLE_W-1:0] cmd_wdata_i,
  input  logic [SAMPLE_W-1:0] pcm_left_i,
  input  logic [SAMPLE_W-1:0] pcm_right_i,
  input  logic [SAMPLE_W-1:0] modem_i,
  input  logic [SAMPLE_W-1:0] io_word_i,
  output logic [FRAME_W-1:0]  frame_o
);
  localparam int FILL_W = SLOT_W - SAMPLE_W;
  localparam int ADDR_FILL_W = SLOT_W - 1 - IDX_W;

  logic             any_vld;
  logic [TAG_W-1:0] tag;

  assign any_vld = |slot_vld_i;

  always_comb begin
    tag = '0;
    if (any_vld) begin
      tag[TAG_W-1] = 1'b1;
      for (int s = 1; s <= NUM_SLOTS; s++) tag[TAG_W-1-s] = slot_vld_i[s];
      tag[CID_W-1:0] = codec_id_i;
    end
  end

  assign frame_o[FRAME_W-1 -: TAG_W] = tag;

  for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_slot
    localparam slot_kind_e  KIND = kind_of_slot(s, NUM_SLOTS);
    localparam sample_src_e SRC  = src_of_slot(s, NUM_SLOTS);
    localparam int          TOP  = slot_top(s, FRAME_W, TAG_W, SLOT_W);
    logic [SLOT_W-1:0] raw;

    if (KIND == SLOT_CMD_ADDR) begin : g_addr
      assign raw = {cmd_read_i, cmd_index_i, {ADDR_FILL_W{1'b0}}};
    end else if (KIND == SLOT_CMD_DATA) begin : g_data
      assign raw = {cmd_wdata_i, {FILL_W{1'b0}}};
    end else if (KIND == SLOT_SAMPLE && SRC == SRC_LEFT) begin : g_left
      assign raw = {pcm_left_i, {FILL_W{1'b0}}};
    end else if (KIND == SLOT_SAMPLE && SRC == SRC_RIGHT) begin : g_right
      assign raw = {pcm_right_i, {FILL_W{1'b0}}};
    end else if (KIND == SLOT_SAMPLE && SRC == SRC_MODEM) begin : g_modem
      assign raw = {modem_i, {FILL_W{1'b0}}};
    end else if (KIND == SLOT_SAMPLE && SRC == SRC_IO) begin : g_io
      assign raw = {io_word_i, {FILL_W{1'b0}}};
    end else begin : g_rsvd
      assign raw = '0;
    end

    assign frame_o[TOP -: SLOT_W] = slot_vld_i[s] ? raw : '0;
  end
endmodule

// File: rtl/aclink_frame_shifter.sv
module aclink_frame_shifter #(
  parameter int FRAME_W = 256
) (
  input  logic               bclk,
  input  logic               rst_n,
  input  logic               shutoff_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdata_o
);
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge bclk) begin
    if (!rst_n || shutoff_i) shreg <= '0;
    else if (load_i)         shreg <= frame_i;
    else                     shreg <= {shreg[FRAME_W-2:0], 1'b0};
  end

  assign sdata_o = shreg[FRAME_W-1];
endmodule

// File: rtl/aclink_frame_tx.sv
module aclink_frame_tx #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int SAMPLE_W  = 16,
  parameter int IDX_W     = 7,
  parameter int CID_W     = 2
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                shutoff_i,
  input  logic [NUM_SLOTS:1]  slot_vld_i,
  input  logic [CID_W-1:0]    codec_id_i,
  input  logic                cmd_read_i,
  input  logic [IDX_W-1:0]    cmd_index_i,
  input  logic [SAMPLE_W-1:0] cmd_wdata_i,
  input  logic [SAMPLE_W-1:0] pcm_left_i,
  input  logic [SAMPLE_W-1:0] pcm_right_i,
  input  logic [SAMPLE_W-1:0] modem_i,
  input  logic [SAMPLE_W-1:0] io_word_i,
  output logic                sdata_o,
  output logic                sync_o,
  output logic                frame_start_o
);
  localparam int FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int POS_W   = $clog2(FRAME_W);

  logic               frame_load;
  logic [POS_W-1:0]   line_pos;
  logic [FRAME_W-1:0] frame_vec;

  aclink_frame_timer #(
    .FRAME_W(FRAME_W), .TAG_W(TAG_W), .POS_W(POS_W)
  ) u_timer (
    .bclk(bclk), .rst_n(rst_n), .shutoff_i(shutoff_i),
    .load_o(frame_load), .sync_o(sync_o), .frame_start_o(frame_start_o),
    .pos_o(line_pos)
  );

  aclink_frame_builder #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .SAMPLE_W(SAMPLE_W),
    .IDX_W(IDX_W), .CID_W(CID_W), .FRAME_W(FRAME_W)
  ) u_builder (
    .slot_vld_i(slot_vld_i), .codec_id_i(codec_id_i), .cmd_read_i(cmd_read_i),
    .cmd_index_i(cmd_index_i), .cmd_wdata_i(cmd_wdata_i), .pcm_left_i(pcm_left_i),
    .pcm_right_i(pcm_right_i), .modem_i(modem_i), .io_word_i(io_word_i),
    .frame_o(frame_vec)
  );

  aclink_frame_shifter #(.FRAME_W(FRAME_W)) u_shifter (
    .bclk(bclk), .rst_n(rst_n), .shutoff_i(shutoff_i), .load_i(frame_load),
    .frame_i(frame_vec), .sdata_o(sdata_o)
  );
endmodule

// File: rtl/aclink_frame_tx_chk.sv
module aclink_frame_tx_chk #(
  parameter int NUM_SLOTS = 12,
  parameter int POS_W     = 8
) (
  input logic               bclk,
  input logic               rst_n,
  input logic               shutoff_i,
  input logic [NUM_SLOTS:1] slot_vld_i,
  input logic               sdata_o,
  input logic               sync_o,
  input logic               frame_start_o,
  input logic               frame_load,
  input logic [POS_W-1:0]   line_pos
);
  AST_FSTART_AT_POS0: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_start_o |-> (line_pos == '0));                                   // R1
  AST_FSTART_SINGLE: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);                                     // R1
  AST_SYNC_OPENS_FRAME: assert property (@(posedge bclk) disable iff (!rst_n)
    $rose(sync_o) |-> frame_start_o);                                      // R2
  AST_TAG_VALID_SET: assert property (@(posedge bclk) disable iff (!rst_n)
    (frame_load && (|slot_vld_i)) |=> sdata_o);                            // R4
  AST_EMPTY_FRAME_ZERO: assert property (@(posedge bclk) disable iff (!rst_n)
    (frame_load && !(|slot_vld_i)) |=> (!sdata_o && sync_o));              // R7
  AST_SHUTOFF_QUIET: assert property (@(posedge bclk) disable iff (!rst_n)
    shutoff_i |=> (!sdata_o && !sync_o && !frame_start_o));                // R9
endmodule

bind aclink_frame_tx aclink_frame_tx_chk #(.NUM_SLOTS(NUM_SLOTS), .POS_W(POS_W)) u_chk (
  .bclk(bclk), .rst_n(rst_n), .shutoff_i(shutoff_i), .slot_vld_i(slot_vld_i),
  .sdata_o(sdata_o), .sync_o(sync_o), .frame_start_o(frame_start_o),
  .frame_load(frame_load), .line_pos(line_pos)
);

// File: tb/tb_aclink_frame_tx.sv
module tb_aclink_frame_tx;
  localparam int CLK_PERIOD = 20;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [12:1] vld;
    logic [1:0]  cid;
    logic        rd;
    logic [6:0]  idx;
    logic [15:0] wd, left, right, modem, io;
  } pat_t;

  logic bclk = 1'b0;
  logic rst_n = 1'b0;
  logic shutoff = 1'b0;
  pat_t cur;
  logic sdata, sync, fstart;

  int tests = 0;
  int fails = 0;

  logic [255:0] exp_q[$];
  logic [255:0] cur_exp, got;
  bit busy = 0;
  int idx = 0;
  int sync_bad = 0;

  always #(CLK_PERIOD/2) bclk = ~bclk;

  aclink_frame_tx dut (
    .bclk(bclk), .rst_n(rst_n), .shutoff_i(shutoff), .slot_vld_i(cur.vld),
    .codec_id_i(cur.cid), .cmd_read_i(cur.rd), .cmd_index_i(cur.idx),
    .cmd_wdata_i(cur.wd), .pcm_left_i(cur.left), .pcm_right_i(cur.right),
    .modem_i(cur.modem), .io_word_i(cur.io), .sdata_o(sdata), .sync_o(sync),
    .frame_start_o(fstart)
  );

  task automatic check(input bit ok, input string what, input logic [255:0] act,
                       input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Reference frame built bit by bit from the requirement text.
  function automatic logic [255:0] model(input pat_t p);
    logic [255:0] f = '0;
    logic [19:0] w;
    if (p.vld == '0) return f;                              // R7
    f[255] = 1'b1;                                          // R4
    for (int s = 1; s <= 12; s++) f[255-s] = p.vld[s];
    f[241:240] = p.cid;
    for (int s = 1; s <= 12; s++) begin
      case (s)
        1:  w = {p.rd, p.idx, 12'h000};                     // R5
        2:  w = {p.wd, 4'h0};
        3:  w = {p.left, 4'h0};                             // R6
        4:  w = {p.right, 4'h0};
        5:  w = {p.modem, 4'h0};
        12: w = {p.io, 4'h0};
        default: w = 20'h0;
      endcase
      if (p.vld[s]) f[239-(s-1)*20 -: 20] = w;
    end
    return f;
  endfunction

  function automatic pat_t mk(input logic [11:0] v, input logic [1:0] c, input logic r,
                              input logic [6:0] i, input logic [15:0] base);
    pat_t p;
    p.vld = v; p.cid = c; p.rd = r; p.idx = i;
    p.wd = base ^ 16'h1234; p.left = base ^ 16'h8001; p.right = base ^ 16'h7FFE;
    p.modem = base ^ 16'hC3C3; p.io = base ^ 16'h0F0F;
    return p;
  endfunction

  task automatic step();
    @(negedge bclk); #1;
  endtask

  task automatic wait_fstart();
    do step(); while (!fstart);
  endtask

  // Monitor: pops one expected frame per frame-start strobe and compares.
  always @(negedge bclk) begin
    if (rst_n) begin
      if (!busy && fstart && exp_q.size() > 0) begin
        cur_exp = exp_q.pop_front();
        busy = 1; idx = 0; got = '0; sync_bad = 0;
      end
      if (busy) begin
        got[255-idx] = sdata;
        if (sync !== (idx < 16)) sync_bad++;
        if (fstart !== (idx == 0)) sync_bad++;
        idx++;
        if (idx == 256) begin
          check(got === cur_exp, "R3 R4 R5 R6 R7 R8 frame contents", got, cur_exp);
          check(sync_bad == 0, "R1 R2 sync/strobe timing mismatches", 256'(sync_bad), 256'(0));
          busy = 0;
        end
      end
    end
  end

  pat_t pats[6];

  initial begin
    pats[0] = mk(12'h000, 2'b11, 1'b1, 7'h55, 16'hFFFF);   // nothing valid, cid ignored
    pats[1] = mk(12'hFFF, 2'b00, 1'b1, 7'h26, 16'h0000);   // every slot valid, read
    pats[2] = mk(12'h003, 2'b10, 1'b0, 7'h7F, 16'hA5A5);   // command write only
    pats[3] = mk(12'h00C, 2'b01, 1'b0, 7'h01, 16'h5A5A);   // PCM pair only
    pats[4] = mk(12'h800, 2'b00, 1'b0, 7'h54, 16'h9999);   // I/O slot only
    pats[5] = mk(12'h020, 2'b01, 1'b1, 7'h10, 16'h3333);   // reserved slot 6 only
    cur = pats[0];
    repeat (4) step();
    check({sdata, sync, fstart} === 3'b000, "R10 outputs during reset",
          256'({sdata, sync, fstart}), 256'(0));
    exp_q.push_back(model(pats[0]));
    rst_n = 1'b1;
    for (int k = 1; k < 6; k++) begin
      wait_fstart();
      cur = ~pats[k];                                       // R8 scrambled mid-frame
      exp_q.push_back(model(pats[k]));
      repeat (100) step();
      cur = pats[k];
    end
    while (exp_q.size() != 0 || busy) step();
    shutoff = 1'b1;
    begin
      int loud = 0;
      for (int c = 0; c < 300; c++) begin
        step();
        if (sdata || sync || fstart) loud++;
      end
      check(loud == 0, "R9 cycles with activity during shut-off", 256'(loud), 256'(0));
    end
    cur = mk(12'hA5F, 2'b10, 1'b1, 7'h3C, 16'h6C6C);
    exp_q.push_back(model(cur));
    shutoff = 1'b0;                                         // R9 restart frame
    step();
    while (exp_q.size() != 0 || busy) step();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge bclk);
    tests++; fails++;
    $display("FAIL R1 watchdog: frames outstanding=%0d expected 0", exp_q.size());
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule